// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block carries out a single DMA transfer unit as an ordered run of bus cycles on a simple synchronous 16-bit bus. A start strobe captures four things: the source address, the destination address, a size select and the wait settings. The sequencer then spends one idle slot that stands in for taking the bus. After that it issues every read at the source, collects the data in a 16-bit holding latch, and issues every write at the destination.

A 16-bit unit at an odd address cannot be done as one aligned word access. It is split into two byte accesses, at the address and then at the address plus one. Each access is held for as many clocks as the coefficient of the region it falls in. An address below a programmable boundary belongs to the register region, which always costs two clocks. Any other address costs one clock, or two when the memory wait setting is on.

When the last write ends, the block raises done for one clock. It also reports how many clocks the accesses took in total.

Top module: `dma_unit_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, busRd, busWr, busBe, busAddr and busWdata are all zero. After reset, busy, done and clkCount are zero.
- R2: A start strobe seen while idle is followed by exactly one clock with busy high and no access before the first read. A start strobe while busy, including the done clock, is ignored. All transfer inputs are sampled only at the accepted strobe.
- R3: With byteMode=1 the unit takes one read at the source and one write at the destination. A byte access to an even address uses the lower lane (busBe=2'b01). A byte access to an odd address uses the upper lane (busBe=2'b10). A written byte is driven on both lanes of busWdata.
- R4: With byteMode=0 and an even source, there is one read with busBe=2'b11. With an odd source, there are two byte reads: first at the source, whose upper lane gives the low byte, then at source+1, whose lower lane gives the high byte.
- R5: With byteMode=0 and an even destination, there is one write with busBe=2'b11 and busWdata={high,low}. With an odd destination, there are two byte writes: the low byte at the destination, then the high byte at destination+1.
- R6: All reads finish before the first write, and busRd and busWr are never high together.
- R7: Each access holds its strobe, address and enables for its coefficient in clocks. The coefficient is 2 when that access's own address is below sfrBound. Otherwise it is 2 if memWaitEn is set and 1 if not.
- R8: done is high for exactly one clock, the clock right after the last write clock. At that clock clkCount equals the total of all access clocks (reads × j + writes × k), and it holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Request to run one transfer unit |
| byteMode | input | 1 | 1 selects an 8-bit unit, 0 a 16-bit unit |
| srcAddr | input | AW | Source byte address |
| dstAddr | input | AW | Destination byte address |
| sfrBound | input | AW | Addresses below this are in the register region |
| memWaitEn | input | 1 | Adds one wait clock to memory-region accesses |
| busAddr | output | AW | Bus byte address |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busBe | output | 2 | Byte lane enables, bit 1 is the upper lane |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data, sampled on the last clock of a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at the end of a unit |
| clkCount | output | CW | Access clocks used by the last unit |

## Verification
The hardest case to reach is a split 16-bit access whose two halves fall in different regions. This happens when the odd source or destination sits exactly one byte below sfrBound, so the first byte access costs two clocks and the second costs one. The stimulus sets sfrBound to the odd address plus one and turns memWaitEn off. The reference model then expects the two halves to have unequal lengths, and expects the total to follow from each access's own region. A second hard case is a start strobe that arrives mid-transfer and on the done clock. In that case the bench also changes the addresses and the size select, to show that none of them leak into the running unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture transfer inputs
    logic rdAct;    // a read access is on the bus
    logic wrAct;    // a write access is on the bus
    logic second;   // second half of a split access
    logic capture;  // last clock of a read access
    logic countEn;  // an access clock is being spent
  } seqCtl_t;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStrobe,
  input  logic       rdSplit,
  input  logic       wrSplit,
  input  logic [3:0] slowMap,
  output seqCtl_t    ctl,
  output logic       busy,
  output logic       done
);
  seqState_e state;
  logic      second;
  logic      waitCnt;
  logic      curSlow;
  logic      lastClk;
  logic      curSplit;

  always_comb begin
    curSlow  = slowMap[{state == ST_WRITE, second}];
    lastClk  = !curSlow || waitCnt;
    curSplit = (state == ST_WRITE) ? wrSplit : rdSplit;

    ctl.load    = (state == ST_IDLE) && startStrobe;
    ctl.rdAct   = (state == ST_READ);
    ctl.wrAct   = (state == ST_WRITE);
    ctl.second  = second;
    ctl.capture = (state == ST_READ) && lastClk;
    ctl.countEn = (state == ST_READ) || (state == ST_WRITE);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      second  <= 1'b0;
      waitCnt <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startStrobe) state <= ST_SLOT;
        ST_SLOT: begin
          state   <= ST_READ;
          second  <= 1'b0;
          waitCnt <= 1'b0;
        end
        ST_READ, ST_WRITE: begin
          if (lastClk) begin
            waitCnt <= 1'b0;
            if (curSplit && !second) begin
              second <= 1'b1;
            end else begin
              second <= 1'b0;
              state  <= (state == ST_READ) ? ST_WRITE : ST_DONE;
            end
          end else begin
            waitCnt <= 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic [AW-1:0] srcAddr,
  input  logic [AW-1:0] dstAddr,
  input  logic          byteMode,
  input  logic [AW-1:0] sfrBound,
  input  logic          memWaitEn,
  input  logic [15:0]   busRdata,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busBe,
  output logic [15:0]   busWdata,
  output logic          busRd,
  output logic          busWr,
  output logic [CW-1:0] clkCount,
  output logic          rdSplit,
  output logic          wrSplit,
  output logic [3:0]    slowMap
);
  localparam int NSLOT = 4;  // rd first, rd second, wr first, wr second

  logic [AW-1:0]    srcQ, dstQ;
  logic             byteQ;
  logic [15:0]      latchQ;
  logic [CW-1:0]    cntQ;
  logic [NSLOT-1:0] slowQ, slowNext;

  // region decode for every possible access, resolved at load time
  for (genvar g = 0; g < NSLOT; g++) begin : gSlow
    logic [AW-1:0] probe;
    assign probe       = ((g >= 2) ? dstAddr : srcAddr) + AW'(g % 2);
    assign slowNext[g] = (probe < sfrBound) || memWaitEn;
  end

  logic [AW-1:0] baseAddr, curAddr;
  logic          active, wide;
  logic [7:0]    laneByte, outByte;

  always_comb begin
    baseAddr = ctl.wrAct ? dstQ : srcQ;
    curAddr  = baseAddr + AW'(ctl.second);
    active   = ctl.rdAct || ctl.wrAct;
    wide     = !byteQ && !baseAddr[0];
    laneByte = curAddr[0] ? busRdata[15:8] : busRdata[7:0];
    outByte  = ctl.second ? latchQ[15:8] : latchQ[7:0];

    busRd    = ctl.rdAct;
    busWr    = ctl.wrAct;
    busAddr  = active ? curAddr : '0;
    if (!active)         busBe = 2'b00;
    else if (wide)       busBe = 2'b11;
    else if (curAddr[0]) busBe = 2'b10;
    else                 busBe = 2'b01;
    if (!ctl.wrAct)      busWdata = '0;
    else if (wide)       busWdata = latchQ;
    else                 busWdata = {outByte, outByte};
  end

  assign rdSplit  = !byteQ && srcQ[0];
  assign wrSplit  = !byteQ && dstQ[0];
  assign slowMap  = slowQ;
  assign clkCount = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ   <= '0;
      dstQ   <= '0;
      byteQ  <= 1'b0;
      slowQ  <= '0;
      latchQ <= '0;
      cntQ   <= '0;
    end else begin
      if (ctl.load) begin
        srcQ   <= srcAddr;
        dstQ   <= dstAddr;
        byteQ  <= byteMode;
        slowQ  <= slowNext;
        latchQ <= '0;
        cntQ   <= '0;
      end else if (ctl.countEn) begin
        cntQ <= cntQ + CW'(1);
      end
      if (ctl.capture) begin
        if (wide)            latchQ        <= busRdata;
        else if (ctl.second) latchQ[15:8]  <= laneByte;
        else                 latchQ[7:0]   <= laneByte;
      end
    end
  end
endmodule

// File: rtl/dma_unit_seq.sv
module dma_unit_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStrobe,
  input  logic          byteMode,
  input  logic [AW-1:0] srcAddr,
  input  logic [AW-1:0] dstAddr,
  input  logic [AW-1:0] sfrBound,
  input  logic          memWaitEn,
  output logic [AW-1:0] busAddr,
  output logic          busRd,
  output logic          busWr,
  output logic [1:0]    busBe,
  output logic [15:0]   busWdata,
  input  logic [15:0]   busRdata,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] clkCount
);
  seqCtl_t    ctl;
  logic       rdSplit, wrSplit;
  logic [3:0] slowMap;

  dma_seq_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe),
    .rdSplit(rdSplit), .wrSplit(wrSplit), .slowMap(slowMap),
    .ctl(ctl), .busy(busy), .done(done)
  );

  dma_seq_dp #(.AW(AW), .CW(CW)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .byteMode(byteMode),
    .sfrBound(sfrBound), .memWaitEn(memWaitEn), .busRdata(busRdata),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busRd(busRd), .busWr(busWr), .clkCount(clkCount),
    .rdSplit(rdSplit), .wrSplit(wrSplit), .slowMap(slowMap)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          startStrobe,
  input logic [AW-1:0] busAddr,
  input logic          busRd,
  input logic          busWr,
  input logic [1:0]    busBe,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] clkCount
);
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R6
  no_read_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !busRd);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startStrobe) |=> (busy && !busRd && !busWr));

  // R1
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |-> (busBe == 2'b00 && busAddr == '0));

  // R3
  lane_on_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> (busBe != 2'b00));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (clkCount >= CW'(2) && clkCount <= CW'(8)));
endmodule

bind dma_unit_seq dma_seq_chk #(.AW(AW), .CW(CW)) chkI (
  .clk(clk), .rstN(rstN), .startStrobe(startStrobe),
  .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busBe(busBe),
  .busy(busy), .done(done), .clkCount(clkCount)
);

// File: tb/dma_unit_seq_test.sv
module dma_unit_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 1'b0;
  logic        byteMode = 1'b0;
  logic [15:0] srcAddr = '0, dstAddr = '0, sfrBound = '0;
  logic        memWaitEn = 1'b0;
  logic [15:0] busAddr, busWdata, busRdata;
  logic        busRd, busWr, busy, done;
  logic [1:0]  busBe;
  logic [3:0]  clkCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_unit_seq uut (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .byteMode(byteMode),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .sfrBound(sfrBound),
    .memWaitEn(memWaitEn), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .busy(busy), .done(done), .clkCount(clkCount)
  );

  // memory model: each byte address holds a fixed pattern
  function automatic int byteAt(int a);
    return ((a * 7 + 3) ^ (a >> 8)) & 8'hFF;
  endfunction

  always_comb begin
    int w;
    w = busAddr & 16'hFFFE;
    busRdata = 16'((byteAt(w + 1) << 8) | byteAt(w));
  end

  typedef struct {
    bit rd; bit wr; int addr; int be; int wd; bit dn; bit bsy; int cnt; string tag;
  } exp_t;

  exp_t q[$];
  int lastCount = 0;

  function automatic exp_t mk(bit rd, bit wr, int addr, int be, int wd,
                              bit dn, bit bsy, int cnt, string tag);
    exp_t e;
    e.rd = rd; e.wr = wr; e.addr = addr & 16'hFFFF; e.be = be; e.wd = wd;
    e.dn = dn; e.bsy = bsy; e.cnt = cnt; e.tag = tag;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string act, string expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual: %s expected: %s", tag, act, expv);
    end
  endtask

  task automatic compareNow(exp_t e);
    string a, x;
    int c;
    c = (e.cnt < 0) ? -1 : int'(clkCount);
    a = $sformatf("rd=%0b wr=%0b a=%04h be=%02b wd=%04h done=%0b busy=%0b cnt=%0d",
                  busRd, busWr, busAddr, busBe, busWdata, done, busy, c);
    x = $sformatf("rd=%0b wr=%0b a=%04h be=%02b wd=%04h done=%0b busy=%0b cnt=%0d",
                  e.rd, e.wr, e.addr[15:0], e.be[1:0], e.wd[15:0], e.dn, e.bsy, e.cnt);
    check(a == x, e.tag, a, x);
    // R6: strobes exclusive on every clock
    check(!(busRd && busWr), "R6", $sformatf("rd=%0b wr=%0b", busRd, busWr), "not both");
  endtask

  // R7: coefficient of one access address
  function automatic int coef(int a, int bound, bit wen);
    return ((a & 16'hFFFF) < bound) ? 2 : (wen ? 2 : 1);
  endfunction

  task automatic addAcc(bit rd, int a, int be, int wd, int n, string tag, inout int sum);
    for (int k = 0; k < n; k++) q.push_back(mk(rd, !rd, a, be, wd, 0, 1, -1, tag));
    sum += n;
  endtask

  task automatic runXfer(int src, int dst, bit bm, int bound, bit wen, bit poke);
    int sum = 0;
    int lo, hi;
    int s1, d1;
    s1 = (src + 1) & 16'hFFFF;
    d1 = (dst + 1) & 16'hFFFF;
    lo = byteAt(src);
    hi = byteAt(s1);
    q.delete();
    q.push_back(mk(0, 0, 0, 0, 0, 0, 1, -1, "R2"));
    if (bm) begin
      addAcc(1, src, (src & 1) ? 2 : 1, 0, coef(src, bound, wen), "R3/R7", sum);
      addAcc(0, dst, (dst & 1) ? 2 : 1, lo * 257, coef(dst, bound, wen), "R3/R7", sum);
    end else begin
      if ((src & 1) == 0) begin
        addAcc(1, src, 3, 0, coef(src, bound, wen), "R4/R7", sum);
      end else begin
        addAcc(1, src, 2, 0, coef(src, bound, wen), "R4/R7", sum);
        addAcc(1, s1, 1, 0, coef(s1, bound, wen), "R4/R7", sum);
      end
      if ((dst & 1) == 0) begin
        addAcc(0, dst, 3, (hi << 8) | lo, coef(dst, bound, wen), "R5/R7", sum);
      end else begin
        addAcc(0, dst, 2, lo * 257, coef(dst, bound, wen), "R5/R7", sum);
        addAcc(0, d1, 1, hi * 257, coef(d1, bound, wen), "R5/R7", sum);
      end
    end
    q.push_back(mk(0, 0, 0, 0, 0, 1, 1, sum, "R8"));

    srcAddr = 16'(src); dstAddr = 16'(dst); byteMode = bm;
    sfrBound = 16'(bound); memWaitEn = wen;
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      compareNow(q[i]);
      if (poke && (i == 1 || i == q.size() - 1)) begin
        // R2: strobe and altered inputs while busy must be ignored
        startStrobe = 1'b1;
        srcAddr = ~srcAddr; dstAddr = ~dstAddr; byteMode = ~byteMode;
        memWaitEn = ~memWaitEn; sfrBound = 16'hFFFF;
      end else begin
        startStrobe = 1'b0;
      end
      @(negedge clk);
    end
    startStrobe = 1'b0;
    lastCount = sum;
    // R8 count held, R2 no restart after done
    compareNow(mk(0, 0, 0, 0, 0, 0, 0, sum, "R2/R8"));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    compareNow(mk(0, 0, 0, 0, 0, 0, 0, 0, "R1"));

    runXfer(16'h0200, 16'h0310, 1, 0, 0, 0);        // R3 byte even->even
    runXfer(16'h0205, 16'h0333, 1, 0, 1, 0);        // R3 byte odd->odd, wait
    runXfer(16'h0400, 16'h0500, 0, 0, 0, 0);        // R4 R5 aligned word
    runXfer(16'h0401, 16'h0502, 0, 0, 0, 0);        // R4 odd source
    runXfer(16'h0600, 16'h0703, 0, 0, 1, 0);        // R5 odd destination, wait
    runXfer(16'h0011, 16'h0021, 0, 16'h0100, 0, 0); // R7 all in register region
    runXfer(16'h0101, 16'h0101, 0, 16'h0102, 0, 0); // R7 split straddles boundary
    runXfer(16'h0050, 16'h0800, 1, 16'h0060, 0, 0); // R7 byte read in register region
    runXfer(16'h0902, 16'h0A04, 1, 0, 0, 1);        // R2 ignored strobes
    runXfer(16'h0903, 16'h0A05, 0, 0, 0, 1);        // R2 ignored on split transfer

    // R1 idle bus quiet for a while
    for (int i = 0; i < 3; i++) begin
      compareNow(mk(0, 0, 0, 0, 0, 0, 0, lastCount, "R1"));
      @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual: running expected: finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule